// File: doc/BRIEF.md
# Periodic Interval Timer

The block makes a periodic tick for an operating system. A 16-bit down counter is loaded with a software-written period. It steps down by one on each slow-clock tick, which is a single-cycle enable input in the bus clock domain. When the count runs out, the counter reloads itself from the period and keeps running. The same event sets a sticky status flag.

The interrupt output is a level. It is the status flag gated by an enable bit, and it is meant to be ORed with other system interrupt sources outside the block. Software clears the flag with a read strobe and controls the enable bit through separate set and clear strobes. A period of 0 selects the longest period, 65536 ticks. Writing the period restarts the count at once.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset the period value is 0, the count is 0, and the status flag, the enable bit and the interrupt are all 0.
- R2: A tick with no period write in that cycle and a count other than 1 lowers `count_o` by one on that edge. The step is modulo 2^16, so 0 becomes 0xFFFF.
- R3: A tick with no period write, when `count_o` is 1, is an expiry. On that edge the status flag is set and the count reloads from `period_o`. A nonzero period P therefore gives one expiry every P ticks, and a period of 0 gives one expiry every 65536 ticks.
- R4: A period write loads both `period_o` and `count_o` with `period_wdata_i` on that edge. A tick in the same cycle is ignored, so it neither decrements nor expires.
- R5: The status flag stays set until a cycle with `status_rd_i` high, and it clears on that edge.
- R6: An expiry in the same cycle as a clearing read leaves the status flag set.
- R7: `irq_o` is high exactly when the status flag and the enable bit are both set.
- R8: `irq_en_set_i` sets the enable bit and `irq_en_clr_i` clears it. When both are high in the same cycle, the clear wins.
- R9: In a cycle with no tick and no period write, the count and the period are unchanged. The status flag is also unchanged unless that cycle has a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow-clock tick enable, one cycle wide |
| period_we_i | input | 1 | Period write strobe |
| period_wdata_i | input | 16 | New period value (0 means 65536) |
| status_rd_i | input | 1 | Status read strobe; clears the flag |
| irq_en_set_i | input | 1 | Interrupt enable set strobe |
| irq_en_clr_i | input | 1 | Interrupt enable clear strobe |
| period_o | output | 16 | Programmed period read-back |
| status_o | output | 1 | Sticky expiry flag |
| irq_en_o | output | 1 | Interrupt enable bit |
| irq_o | output | 1 | Level interrupt request |
| count_o | output | 16 | Live counter value |

## Verification
The bench runs several directed cases:
- A short period with a tick every cycle fixes the exact expiry tick and the reload value.
- A period of 0 run for a full 65536 ticks separates the maximum-period meaning from an immediate expiry.
- Collision cases pit a write against a tick, an expiry against a clearing read, and a set strobe against a clear strobe. Each of these tells apart the chosen priority from its reverse.

A long run of seeded random ticks, writes, reads and enable strobes then drives small periods. Gaps between ticks check the hold behaviour against a cycle-by-cycle model in the bench.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned PIT_W = 16;
  typedef logic [PIT_W-1:0] pit_val_t;
endpackage

// File: rtl/pit_period_reg.sv
module pit_period_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] period_o
);
  logic [W-1:0] period_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   period_q <= RST_VAL;
    else if (we_i) period_q <= wdata_i;
  end

  assign period_o = period_q;
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_val_i,
  output logic [W-1:0] count_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         expire;

  // a write in the same cycle swallows the tick
  assign expire = tick_i & ~load_i & (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= RST_VAL;
    else if (load_i)   cnt_q <= load_val_i;
    else if (expire)   cnt_q <= reload_val_i;  // 0 reloads as 65536 ticks
    else if (tick_i)   cnt_q <= cnt_q - ONE;
  end

  assign count_o  = cnt_q;
  assign expire_o = expire;
endmodule

// File: rtl/pit_irq_ctl.sv
module pit_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic rd_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  output logic status_o,
  output logic en_o,
  output logic irq_o
);
  logic status_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      status_q <= expire_i | (status_q & ~rd_i);  // set beats clear
      if (en_clr_i)      en_q <= 1'b0;
      else if (en_set_i) en_q <= 1'b1;
    end
  end

  assign status_o = status_q;
  assign en_o     = en_q;
  assign irq_o    = status_q & en_q;
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer #(
  parameter int unsigned W = pit_pkg::PIT_W,
  parameter logic [W-1:0] RST_PERIOD = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         period_we_i,
  input  logic [W-1:0] period_wdata_i,
  input  logic         status_rd_i,
  input  logic         irq_en_set_i,
  input  logic         irq_en_clr_i,
  output logic [W-1:0] period_o,
  output logic         status_o,
  output logic         irq_en_o,
  output logic         irq_o,
  output logic [W-1:0] count_o
);
  logic [W-1:0] period;
  logic         expire;

  pit_period_reg #(.W(W), .RST_VAL(RST_PERIOD)) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (period_we_i),
    .wdata_i  (period_wdata_i),
    .period_o (period)
  );

  pit_down_counter #(.W(W), .RST_VAL(RST_PERIOD)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .load_i       (period_we_i),
    .load_val_i   (period_wdata_i),
    .reload_val_i (period),
    .count_o      (count_o),
    .expire_o     (expire)
  );

  pit_irq_ctl u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .rd_i     (status_rd_i),
    .en_set_i (irq_en_set_i),
    .en_clr_i (irq_en_clr_i),
    .status_o (status_o),
    .en_o     (irq_en_o),
    .irq_o    (irq_o)
  );

  assign period_o = period;
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         period_we_i,
  input logic [W-1:0] period_wdata_i,
  input logic         status_rd_i,
  input logic         irq_en_set_i,
  input logic         irq_en_clr_i,
  input logic [W-1:0] period_o,
  input logic         status_o,
  input logic         irq_en_o,
  input logic         irq_o,
  input logic [W-1:0] count_o
);
  localparam logic [W-1:0] ONE = W'(1);

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_we_i |=> (count_o == $past(period_wdata_i)) && (period_o == $past(period_wdata_i))); // R4
  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !period_we_i && count_o != ONE) |=> count_o == $past(count_o) - ONE); // R2
  AST_EXPIRE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !period_we_i && count_o == ONE) |=> status_o && count_o == $past(period_o)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !period_we_i) |=> $stable(count_o) && $stable(period_o)); // R9
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !status_rd_i) |=> status_o); // R5
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !(tick_i && !period_we_i && count_o == ONE)) |=> !status_o); // R5
  AST_READ_VS_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && tick_i && !period_we_i && count_o == ONE) |=> status_o); // R6
  AST_EN_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_clr_i |=> !irq_en_o); // R8
  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_set_i && !irq_en_clr_i) |=> irq_en_o); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_o |-> !irq_o); // R7
endmodule

bind periodic_tick_timer pit_checker #(.W(W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tick_i         (tick_i),
  .period_we_i    (period_we_i),
  .period_wdata_i (period_wdata_i),
  .status_rd_i    (status_rd_i),
  .irq_en_set_i   (irq_en_set_i),
  .irq_en_clr_i   (irq_en_clr_i),
  .period_o       (period_o),
  .status_o       (status_o),
  .irq_en_o       (irq_en_o),
  .irq_o          (irq_o),
  .count_o        (count_o)
);

// File: tb/sim_periodic_tick_timer.sv
module sim_periodic_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick = 1'b0, we = 1'b0, rd = 1'b0, es = 1'b0, ec = 1'b0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] period_o, count_o;
  logic         status_o, irq_en_o, irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  logic [W-1:0] m_per = '0, m_cnt = '0;
  logic         m_st = 1'b0, m_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_tick_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .period_we_i(we),
    .period_wdata_i(wd), .status_rd_i(rd), .irq_en_set_i(es), .irq_en_clr_i(ec),
    .period_o(period_o), .status_o(status_o), .irq_en_o(irq_en_o),
    .irq_o(irq_o), .count_o(count_o)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] next_cnt(input logic t, input logic w, input logic [W-1:0] d,
                                            input logic [W-1:0] c, input logic [W-1:0] p);
    if (w)           return d;
    if (t && c == 1) return p;
    if (t)           return c - 1'b1;
    return c;
  endfunction

  task automatic step(input logic t, input logic w, input logic [W-1:0] d,
                      input logic r, input logic s, input logic c);
    logic exp_e;
    logic [W-1:0] n_cnt;
    string cr, sr;
    @(negedge clk);
    tick = t; we = w; wd = d; rd = r; es = s; ec = c;
    exp_e = t && !w && (m_cnt == 1);
    n_cnt = next_cnt(t, w, d, m_cnt, m_per);
    cr = w ? "R4" : exp_e ? "R3" : t ? "R2" : "R9";
    sr = (exp_e && r) ? "R6" : r ? "R5" : exp_e ? "R3" : "R9";
    @(posedge clk);
    #1;
    if (w) m_per = d;
    m_cnt = n_cnt;
    m_st  = exp_e | (m_st & !r);
    m_en  = c ? 1'b0 : s ? 1'b1 : m_en;
    chk(cr, "count", count_o, m_cnt);
    chk(w ? "R4" : "R9", "period", period_o, m_per);
    chk(sr, "status", W'(status_o), W'(m_st));
    chk("R8", "enable", W'(irq_en_o), W'(m_en));
    chk("R7", "irq", W'(irq_o), W'(m_st & m_en));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "period", period_o, '0);
    chk("R1", "count", count_o, '0);
    chk("R1", "status", W'(status_o), '0);
    chk("R1", "enable", W'(irq_en_o), '0);
    chk("R1", "irq", W'(irq_o), '0);
    @(negedge clk); rst_ni = 1'b1;

    // R3 period 3, tick every cycle: expiry every third tick
    step(0, 1, 16'd3, 0, 1, 0);
    for (int i = 0; i < 9; i++) step(1, 0, '0, 0, 0, 0);
    chk("R3", "status after 9 ticks", W'(status_o), 16'd1);
    chk("R7", "irq enabled", W'(irq_o), 16'd1);
    // R5 read clears
    step(0, 0, '0, 1, 0, 0);
    chk("R5", "status cleared", W'(status_o), 16'd0);
    // R6 expiry and read in the same cycle (count is 3 -> two ticks then expire with read)
    step(1, 0, '0, 0, 0, 0);
    step(1, 0, '0, 0, 0, 0);
    step(1, 0, '0, 1, 0, 0);
    chk("R6", "status kept", W'(status_o), 16'd1);
    // R4 write and tick same cycle at count 1
    step(0, 1, 16'd1, 1, 0, 0);
    step(1, 1, 16'd5, 0, 0, 0);
    chk("R4", "tick ignored, no expiry", W'(status_o), 16'd0);
    chk("R4", "count loaded", count_o, 16'd5);
    // R8 set and clear together
    step(0, 0, '0, 0, 1, 1);
    chk("R8", "clear wins", W'(irq_en_o), 16'd0);
    // R9 idle cycles
    for (int i = 0; i < 4; i++) step(0, 0, '0, 0, 0, 0);
    // R3 period 0: 65536 ticks
    step(0, 1, 16'd0, 0, 1, 0);
    for (int i = 0; i < 65535; i++) step(1, 0, '0, 0, 0, 0);
    chk("R3", "no expiry before 65536", W'(status_o), 16'd0);
    step(1, 0, '0, 0, 0, 0);
    chk("R3", "expiry at 65536", W'(status_o), 16'd1);
    chk("R2", "count wrapped to reload 0", count_o, 16'd0);

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      logic t, w, r, s, c;
      logic [W-1:0] d;
      t = ($urandom % 3) != 0;
      w = ($urandom % 25) == 0;
      d = W'(1 + $urandom % 7);
      r = ($urandom % 5) == 0;
      s = ($urandom % 10) == 0;
      c = ($urandom % 12) == 0;
      step(t, w, d, r, s, c);
    end

    done = 1;
    finish_run();
  end
endmodule